// File: doc/BRIEF.md
# Daisy-Chained Interrupt Node

This block is the per-device interrupt node of an active-low, daisy-chained interrupt scheme. Each node sits between a neighbour nearer the CPU (upstream) and a neighbour farther from it (downstream). The request line runs upstream and the grant line runs downstream. Position in the chain sets priority, so a node nearer the CPU wins. No node knows where it sits in the chain.

The device behind the node raises a one-cycle request pulse and supplies the handler address. The node queues these pulses in a small saturating counter. It raises its own request only when the chain around it is quiet. During its own grant it places the handler address on the shared data bus, with an output enable.

While the node has nothing of its own to do, it forwards both chain lines unchanged. The grant line is never registered, so a downstream node always sees grant fall and rise in the same cycle as the CPU drives it.

Top module: `irq_chain_node`

## Requirements
- R1: Outside its own transaction the node drives int_n_o equal to int_n_i in the same cycle, with no register in between.
- R2: Outside its own transaction the node drives grant_n_o equal to grant_n_i combinationally in the same cycle.
- R3: A pending count above zero makes the node pull int_n_o low. This happens on the second rising edge after the request pulse, provided int_n_i and grant_n_i were both high at the first edge.
- R4: From the edge on which the node raises its own request until it returns to idle, grant_n_o stays high. In that window int_n_i does not reach int_n_o.
- R5: Once grant_n_i is low while the node requests, the next edge releases int_n_o (high). From then on data_o equals isr_addr_i and data_oe_o is 1 for as long as grant_n_i stays low.
- R6: data_oe_o falls in the same cycle grant_n_i rises. data_oe_o is never 1 while grant_n_i is high, and data_o is 0 whenever data_oe_o is 0.
- R7: Suppose int_n_i or grant_n_i is low at an edge while the node is idle. The node then starts no request of its own until both lines have been seen high together at an edge.
- R8: Request pulses add to a 4-bit pending count that saturates at 15. Each completed grant removes one. A pulse in the same cycle as a completion leaves the count unchanged.
- R9: After reset, data_oe_o is 0, data_o is 0, the pending count is zero, and both chain lines pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | 1 | One-cycle interrupt request pulse from the device |
| isr_addr_i | input | DATA_W | Handler address presented during grant |
| int_n_i | input | 1 | Request from the downstream neighbour, active low |
| int_n_o | output | 1 | Request toward the upstream neighbour, active low |
| grant_n_i | input | 1 | Grant from the upstream neighbour, active low |
| grant_n_o | output | 1 | Grant toward the downstream neighbour, active low |
| data_o | output | DATA_W | Data-bus value, zero unless enabled |
| data_oe_o | output | 1 | Data-bus output enable |

## Verification
The chain lines are first toggled with no local request pending, which tests pure forwarding against any clocked path. A single local request is timed edge by edge to pin down request, address and release cycles. A downstream request that starts before the local one must be served first. A downstream request that arrives during the local one must stay hidden until the node returns to idle, which separates pass-through from ownership. Bursts of local pulses are drained to a count. These cover queuing, saturation at 15, and a pulse coinciding with a completed grant.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS_BUSY,
    ST_REQUEST,
    ST_ACK,
    ST_WAIT_RELEASE
  } node_state_e;
endpackage

// File: rtl/irq_pending_cnt.sv
module irq_pending_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nonzero_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
    else if (dec_i && !inc_i && cnt_q != '0)      cnt_q <= cnt_q - CNT_ONE;
  end

  assign cnt_o     = cnt_q;
  assign nonzero_o = (cnt_q != '0);

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && inc_i && !dec_i) |=> cnt_q == CNT_MAX);
  a_r8_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CNT_MAX && inc_i && !dec_i) |=> cnt_q == $past(cnt_q) + CNT_ONE);
  a_r8_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_node_fsm.sv
module irq_node_fsm
  import irq_chain_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        int_n_i,
  input  logic        grant_n_i,
  input  logic        pending_i,
  output node_state_e state_o,
  output logic        done_o
);
  node_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (!int_n_i || !grant_n_i) state_d = ST_PASS_BUSY;  // downstream first
        else if (pending_i)         state_d = ST_REQUEST;
      ST_PASS_BUSY:
        if (int_n_i && grant_n_i)   state_d = ST_IDLE;
      ST_REQUEST:
        if (!grant_n_i)             state_d = ST_ACK;
      ST_ACK:
        if (grant_n_i)              state_d = ST_WAIT_RELEASE;
      ST_WAIT_RELEASE:              state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign done_o  = (state_q == ST_ACK) && grant_n_i;

  a_r7_wait_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PASS_BUSY && !(int_n_i && grant_n_i)) |=> state_q != ST_REQUEST);
  a_r5_ack_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && grant_n_i) |=> state_q == ST_WAIT_RELEASE);
endmodule

// File: rtl/irq_node_out.sv
module irq_node_out
  import irq_chain_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  node_state_e       state_i,
  input  logic              int_n_i,
  input  logic              grant_n_i,
  input  logic [DATA_W-1:0] isr_addr_i,
  output logic              int_n_o,
  output logic              grant_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  always_comb begin
    int_n_o   = int_n_i;
    grant_n_o = grant_n_i;
    data_oe_o = 1'b0;
    unique case (state_i)
      ST_REQUEST: begin
        int_n_o   = 1'b0;
        grant_n_o = 1'b1;
      end
      ST_ACK: begin
        int_n_o   = 1'b1;
        grant_n_o = 1'b1;
        data_oe_o = !grant_n_i;  // drop with grant, no clock in between
      end
      ST_WAIT_RELEASE: begin
        int_n_o   = 1'b1;
        grant_n_o = 1'b1;
      end
      default: ;
    endcase
    data_o = data_oe_o ? isr_addr_i : '0;
  end
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
  import irq_chain_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_req_i,
  input  logic [DATA_W-1:0] isr_addr_i,
  input  logic              int_n_i,
  output logic              int_n_o,
  input  logic              grant_n_i,
  output logic              grant_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  node_state_e      state;
  logic             done;
  logic             pending_nz;
  logic [CNT_W-1:0] pending_cnt;

  irq_pending_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (dev_req_i),
    .dec_i     (done),
    .cnt_o     (pending_cnt),
    .nonzero_o (pending_nz)
  );

  irq_node_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_n_i   (int_n_i),
    .grant_n_i (grant_n_i),
    .pending_i (pending_nz),
    .state_o   (state),
    .done_o    (done)
  );

  irq_node_out #(.DATA_W(DATA_W)) i_out (
    .state_i    (state),
    .int_n_i    (int_n_i),
    .grant_n_i  (grant_n_i),
    .isr_addr_i (isr_addr_i),
    .int_n_o    (int_n_o),
    .grant_n_o  (grant_n_o),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

  a_r6_oe_in_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !grant_n_i);
  a_r4_no_shared_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_n_i && !grant_n_o) |-> !data_oe_o);
  a_r3_req_has_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_n_o && int_n_i) |-> (pending_cnt != '0));
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_REQUEST && !grant_n_i) |=> int_n_o);
endmodule

// File: tb/test_irq_chain_node.sv
module test_irq_chain_node;
  localparam int DW = 16;
  localparam logic [DW-1:0] ADDR = 16'h3A5C;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          dev_req = 1'b0;
  logic          int_n_i = 1'b1;
  logic          grant_n_i = 1'b1;
  logic          int_n_o, grant_n_o, data_oe_o;
  logic [DW-1:0] data_o;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  irq_chain_node #(.DATA_W(DW), .CNT_W(4)) i_irq_chain_node (
    .clk_i(clk), .rst_ni(rst_ni), .dev_req_i(dev_req), .isr_addr_i(ADDR),
    .int_n_i(int_n_i), .int_n_o(int_n_o), .grant_n_i(grant_n_i),
    .grant_n_o(grant_n_o), .data_o(data_o), .data_oe_o(data_oe_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dev_req = 1'b1;
    end
    @(negedge clk); dev_req = 1'b0;
  endtask

  // wait for a request and act as CPU for one grant
  task automatic serve_one(output bit got);
    got = 1'b0;
    for (int k = 0; k < 6 && !got; k++) begin
      tick();
      if (!int_n_o) got = 1'b1;
    end
    if (!got) return;
    @(negedge clk); grant_n_i = 1'b0; #1;
    chk("R4 grant held", grant_n_o, 1);
    chk("R6 no drive before ack", data_oe_o, 0);
    tick();
    chk("R5 request released", int_n_o, 1);
    chk("R5 oe", data_oe_o, 1);
    chk("R5 address", data_o, ADDR);
    @(negedge clk); grant_n_i = 1'b1; #1;
    chk("R6 oe drops with grant", data_oe_o, 0);
    chk("R6 bus zero", data_o, 0);
    tick();
    chk("R4 grant held after", grant_n_o, 1);
    tick();
  endtask

  task automatic drain(output int served);
    bit got;
    served = 0;
    do begin
      serve_one(got);
      if (got) served++;
    end while (got && served < 40);
  endtask

  task automatic t_reset();
    #1;
    chk("R9 oe", data_oe_o, 0);
    chk("R9 data", data_o, 0);
    chk("R9 int pass", int_n_o, 1);
    chk("R9 grant pass", grant_n_o, 1);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    chk("R9 no pending", int_n_o, 1);
  endtask

  task automatic t_pass();
    @(negedge clk); int_n_i = 1'b0; #1;
    chk("R1 int low passes", int_n_o, 0);
    @(negedge clk); grant_n_i = 1'b0; #1;
    chk("R2 grant low passes", grant_n_o, 0);
    chk("R2 no drive", data_oe_o, 0);
    @(negedge clk); int_n_i = 1'b1; #1;
    chk("R1 int high passes", int_n_o, 1);
    @(negedge clk); grant_n_i = 1'b1; #1;
    chk("R2 grant high passes", grant_n_o, 1);
    repeat (3) tick();
    chk("R1 idle stays high", int_n_o, 1);
  endtask

  task automatic t_single();
    int served;
    @(negedge clk); dev_req = 1'b1;
    @(negedge clk); dev_req = 1'b0; #1;
    chk("R3 not yet", int_n_o, 1);
    tick();
    chk("R3 request at second edge", int_n_o, 0);
    drain(served);
    chk("R8 single served once", served, 1);
  endtask

  task automatic t_downstream_first();
    int served;
    @(negedge clk); int_n_i = 1'b0;
    pulse(1);
    repeat (3) tick();
    chk("R7 downstream passes", int_n_o, 0);
    @(negedge clk); grant_n_i = 1'b0; #1;
    chk("R7 grant to downstream", grant_n_o, 0);
    chk("R7 no drive", data_oe_o, 0);
    @(negedge clk); int_n_i = 1'b1; #1;
    chk("R7 downstream released", int_n_o, 1);
    repeat (2) tick();
    chk("R7 still waits on grant", int_n_o, 1);
    @(negedge clk); grant_n_i = 1'b1; #1;
    chk("R7 quiet", int_n_o, 1);
    tick();
    chk("R7 idle edge", int_n_o, 1);
    tick();
    chk("R3 own request after quiet", int_n_o, 0);
    drain(served);
    chk("R7 own served", served, 1);
  endtask

  task automatic t_downstream_during_own();
    pulse(1);
    repeat (2) tick();
    chk("R3 own request", int_n_o, 0);
    @(negedge clk); int_n_i = 1'b0; #1;
    chk("R4 own request kept", int_n_o, 0);
    @(negedge clk); grant_n_i = 1'b0; #1;
    chk("R4 grant not forwarded", grant_n_o, 1);
    tick();
    chk("R4 downstream hidden in ack", int_n_o, 1);
    chk("R5 addr", data_o, ADDR);
    @(negedge clk); grant_n_i = 1'b1; #1;
    chk("R6 released", data_oe_o, 0);
    tick();
    chk("R4 hidden in release", int_n_o, 1);
    tick();
    chk("R1 downstream passes after", int_n_o, 0);
    @(negedge clk); grant_n_i = 1'b0; #1;
    chk("R2 grant forwarded", grant_n_o, 0);
    chk("R2 no drive", data_oe_o, 0);
    @(negedge clk); int_n_i = 1'b1;
    @(negedge clk); grant_n_i = 1'b1;
    repeat (4) tick();
    chk("R8 nothing left", int_n_o, 1);
  endtask

  task automatic t_queue();
    int served;
    pulse(3);
    drain(served);
    chk("R8 three queued", served, 3);
  endtask

  task automatic t_saturate();
    int served;
    pulse(20);
    drain(served);
    chk("R8 saturates at 15", served, 15);
  endtask

  task automatic t_inc_dec();
    int served;
    pulse(1);
    repeat (2) tick();
    chk("R3 request", int_n_o, 0);
    @(negedge clk); grant_n_i = 1'b0;
    @(negedge clk); grant_n_i = 1'b1; dev_req = 1'b1;
    @(negedge clk); dev_req = 1'b0;
    drain(served);
    chk("R8 pulse with completion", served, 1);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_single();
    t_downstream_first();
    t_downstream_during_own();
    t_queue();
    t_saturate();
    t_inc_dec();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule